// File: doc/BRIEF.md
# Remote Reconfiguration Supervisor

This block decides when a device should reload its configuration and which image it should load. It runs in one of two modes. In factory mode the safe image is running and software may rewrite the control word. In application mode an upgraded image is running, the control word is locked, and an optional user watchdog guards the image. Software in factory mode writes the start address of the application image, sets the application flag, and then raises a user reconfiguration trigger. The block answers with a one-cycle request that carries that address.

Five causes can trigger a reload: a CRC error, an external error pulse, a user request, an external configuration reset, and watchdog expiry. Every cause other than the user request is an error. An error drops the block back to factory mode, so the request carries address zero. The causes seen in the triggering cycle are kept in a 5-bit status word until the next trigger. The watchdog limit comes from a 12-bit field placed above `WD_SHIFT` zero bits, which makes a wide terminal count.

Top module: `reconfig_supervisor`

## Requirements
- R1: After a synchronous reset the application flag, start address, watchdog enable, timeout field, status word and `req_valid` are all zero.
- R2: In factory mode (`app_mode`=0), one `wr_en` cycle loads all four control fields together. A read with `rd_sel`=0 returns them one cycle after `rd_en`, with `rd_valid` high. The read layout is: bit 0 the application flag, bits 24:1 the start address, bit 25 the watchdog enable, bits 37:26 the timeout.
- R3: In application mode, `wr_en` has no effect on any control field.
- R4: With the application flag and the watchdog enable both set, the counter starts at 0 and counts active cycles. It fires when it equals {timeout, `WD_SHIFT` zeros}. A write that enables it at edge E0 produces `req_valid` after edge E(T+1), where T is that terminal value.
- R5: A `wd_kick` pulse clears the counter. The count to expiry then restarts from zero.
- R6: The watchdog never fires while the watchdog enable is clear or the block is in factory mode.
- R7: Four causes are error causes: CRC (status bit 0), external error (bit 1), configuration reset (bit 3) and watchdog (bit 4). Any of them clears the application flag, and the request it produces carries address 0.
- R8: A user trigger alone (status bit 2) produces a request that carries the stored start address if the flag is set, and 0 otherwise. It leaves the flag unchanged.
- R9: On a trigger cycle the status word is replaced by the full set of causes seen in that cycle. Causes that arrive together all appear together. Between triggers the word holds its value. It can be read with `rd_sel`=1 in bits 4:0, with the upper bits zero.
- R10: `req_valid` is high for exactly the one cycle after each trigger cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control write strobe |
| wr_app | input | 1 | Application flag to write |
| wr_start | input | ADDR_W | Start address to write |
| wr_wd_en | input | 1 | Watchdog enable to write |
| wr_timeout | input | WD_W | Watchdog timeout field to write |
| rd_en | input | 1 | Read strobe |
| rd_sel | input | 1 | 0 selects the control word, 1 selects status |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | ADDR_W+WD_W+2 | Registered read data |
| wd_kick | input | 1 | Clears the watchdog counter |
| trig_crc | input | 1 | CRC error cause |
| trig_ext_err | input | 1 | External error cause |
| trig_user | input | 1 | User reconfiguration cause |
| trig_cfg_rst | input | 1 | External configuration reset cause |
| app_mode | output | 1 | Current application flag |
| status | output | 5 | Causes of the last trigger |
| req_valid | output | 1 | Reconfiguration request pulse |
| req_addr | output | ADDR_W | Address to load with the request |

## Verification
Each result has a fixed latency. Cause inputs held for one cycle show up in `req_valid`, `req_addr`, `status` and `app_mode` right after that clock edge. Read data follows `rd_en` by one edge. A watchdog enabled at edge E0 fires at edge T+1. The bench changes inputs on the falling edge and samples on the next falling edge, so every check falls on the exact edge where a result is due. The watchdog tests also check the edge just before expiry, which catches an off-by-one in the terminal compare. They run with `WD_SHIFT` reduced so the expiry edge is reached quickly.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
  localparam int NCAUSE = 5;
  localparam int C_CRC  = 0;
  localparam int C_EXT  = 1;
  localparam int C_USER = 2;
  localparam int C_CFG  = 3;
  localparam int C_WDOG = 4;
  typedef logic [NCAUSE-1:0] cause_t;
  localparam cause_t ERROR_MASK = ~(cause_t'(1) << C_USER);
endpackage

// File: rtl/rcs_ctrl_regs.sv
module rcs_ctrl_regs #(
  parameter int ADDR_W = 24,
  parameter int WD_W   = 12,
  localparam int CTRL_W = ADDR_W + WD_W + 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic                  wr_app,
  input  logic [ADDR_W-1:0]     wr_start,
  input  logic                  wr_wd_en,
  input  logic [WD_W-1:0]       wr_timeout,
  input  logic                  fallback,
  input  logic                  rd_en,
  input  logic                  rd_sel,
  input  rcs_pkg::cause_t       status_in,
  output logic                  app_o,
  output logic [ADDR_W-1:0]     start_o,
  output logic                  wd_en_o,
  output logic [WD_W-1:0]       timeout_o,
  output logic                  rd_valid,
  output logic [CTRL_W-1:0]     rd_data
);
  import rcs_pkg::*;

  logic              app_q;
  logic [ADDR_W-1:0] start_q;
  logic              wd_en_q;
  logic [WD_W-1:0]   timeout_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      app_q     <= 1'b0;
      start_q   <= '0;
      wd_en_q   <= 1'b0;
      timeout_q <= '0;
    end else begin
      if (wr_en && !app_q) begin
        app_q     <= wr_app;
        start_q   <= wr_start;
        wd_en_q   <= wr_wd_en;
        timeout_q <= wr_timeout;
      end
      if (fallback) app_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) begin
        if (rd_sel) rd_data <= {{(CTRL_W-NCAUSE){1'b0}}, status_in};
        else        rd_data <= {timeout_q, wd_en_q, start_q, app_q};
      end
    end
  end

  assign app_o     = app_q;
  assign start_o   = start_q;
  assign wd_en_o   = wd_en_q;
  assign timeout_o = timeout_q;

  AST_FALLBACK_FLAG: assert property (@(posedge clk) disable iff (rst)
    fallback |=> !app_q); // R7
  AST_APP_LOCK: assert property (@(posedge clk) disable iff (rst)
    (app_q && !fallback) |=> ($stable(start_q) && $stable(timeout_q) && $stable(wd_en_q) && app_q)); // R3
  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid); // R2
endmodule

// File: rtl/rcs_watchdog.sv
module rcs_watchdog #(
  parameter int WD_W     = 12,
  parameter int WD_SHIFT = 17,
  localparam int CNT_W   = WD_W + WD_SHIFT
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            app,
  input  logic            wd_en,
  input  logic [WD_W-1:0] timeout,
  input  logic            kick,
  input  logic            restart,
  output logic            fire
);
  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] terminal;
  logic             active;

  generate
    if (WD_SHIFT > 0) begin : g_shifted
      assign terminal = {timeout, {WD_SHIFT{1'b0}}};
    end else begin : g_plain
      assign terminal = timeout;
    end
  endgenerate

  assign active = app && wd_en;
  assign fire   = active && (count_q == terminal);

  always_ff @(posedge clk) begin
    if (rst || !active || kick || restart) count_q <= '0;
    else                                   count_q <= count_q + CNT_W'(1);
  end

  AST_WD_BOUND: assert property (@(posedge clk) disable iff (rst)
    active |-> (count_q <= terminal)); // R4
  AST_WD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !active |=> (count_q == '0)); // R6
  AST_WD_KICK: assert property (@(posedge clk) disable iff (rst)
    kick |=> (count_q == '0)); // R5
endmodule

// File: rtl/rcs_cause_unit.sv
module rcs_cause_unit #(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trig_crc,
  input  logic              trig_ext,
  input  logic              trig_user,
  input  logic              trig_cfg,
  input  logic              wd_fire,
  input  logic              app,
  input  logic [ADDR_W-1:0] start,
  output logic              fallback,
  output logic              any_cause,
  output rcs_pkg::cause_t   status,
  output logic              req_valid,
  output logic [ADDR_W-1:0] req_addr
);
  import rcs_pkg::*;

  cause_t causes;

  always_comb begin
    causes         = '0;
    causes[C_CRC]  = trig_crc;
    causes[C_EXT]  = trig_ext;
    causes[C_USER] = trig_user;
    causes[C_CFG]  = trig_cfg;
    causes[C_WDOG] = wd_fire;
  end

  assign any_cause = |causes;
  assign fallback  = |(causes & ERROR_MASK);

  always_ff @(posedge clk) begin
    if (rst) begin
      status    <= '0;
      req_valid <= 1'b0;
      req_addr  <= '0;
    end else begin
      req_valid <= any_cause;
      if (any_cause) begin
        status   <= causes;
        req_addr <= (!fallback && app) ? start : '0;
      end
    end
  end

  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (rst)
    any_cause |=> req_valid); // R10
  AST_REQ_QUIET: assert property (@(posedge clk) disable iff (rst)
    !any_cause |=> !req_valid); // R10
  AST_FALLBACK_ADDR: assert property (@(posedge clk) disable iff (rst)
    fallback |=> (req_addr == '0)); // R7
  AST_USER_ADDR: assert property (@(posedge clk) disable iff (rst)
    (any_cause && !fallback && app) |=> (req_addr == $past(start))); // R8
  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !any_cause |=> $stable(status)); // R9
endmodule

// File: rtl/reconfig_supervisor.sv
module reconfig_supervisor #(
  parameter int ADDR_W   = 24,
  parameter int WD_W     = 12,
  parameter int WD_SHIFT = 17,
  localparam int CTRL_W  = ADDR_W + WD_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_app,
  input  logic [ADDR_W-1:0] wr_start,
  input  logic              wr_wd_en,
  input  logic [WD_W-1:0]   wr_timeout,
  input  logic              rd_en,
  input  logic              rd_sel,
  output logic              rd_valid,
  output logic [CTRL_W-1:0] rd_data,
  input  logic              wd_kick,
  input  logic              trig_crc,
  input  logic              trig_ext_err,
  input  logic              trig_user,
  input  logic              trig_cfg_rst,
  output logic              app_mode,
  output logic [4:0]        status,
  output logic              req_valid,
  output logic [ADDR_W-1:0] req_addr
);
  import rcs_pkg::*;

  logic              app_w;
  logic [ADDR_W-1:0] start_w;
  logic              wd_en_w;
  logic [WD_W-1:0]   timeout_w;
  logic              fallback_w;
  logic              any_w;
  logic              fire_w;
  cause_t            status_w;

  rcs_ctrl_regs #(.ADDR_W(ADDR_W), .WD_W(WD_W)) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_app(wr_app), .wr_start(wr_start),
    .wr_wd_en(wr_wd_en), .wr_timeout(wr_timeout),
    .fallback(fallback_w),
    .rd_en(rd_en), .rd_sel(rd_sel), .status_in(status_w),
    .app_o(app_w), .start_o(start_w), .wd_en_o(wd_en_w), .timeout_o(timeout_w),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  rcs_watchdog #(.WD_W(WD_W), .WD_SHIFT(WD_SHIFT)) u_wd (
    .clk(clk), .rst(rst),
    .app(app_w), .wd_en(wd_en_w), .timeout(timeout_w),
    .kick(wd_kick), .restart(any_w), .fire(fire_w)
  );

  rcs_cause_unit #(.ADDR_W(ADDR_W)) u_cause (
    .clk(clk), .rst(rst),
    .trig_crc(trig_crc), .trig_ext(trig_ext_err), .trig_user(trig_user),
    .trig_cfg(trig_cfg_rst), .wd_fire(fire_w),
    .app(app_w), .start(start_w),
    .fallback(fallback_w), .any_cause(any_w),
    .status(status_w), .req_valid(req_valid), .req_addr(req_addr)
  );

  assign app_mode = app_w;
  assign status   = status_w;
endmodule

// File: tb/tb_reconfig_supervisor.sv
module tb_reconfig_supervisor;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 24;
  localparam int WD_W = 12;
  localparam int WD_SHIFT = 2;
  localparam int CTRL_W = ADDR_W + WD_W + 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 0, wr_app = 0, wr_wd_en = 0;
  logic [ADDR_W-1:0] wr_start = '0;
  logic [WD_W-1:0] wr_timeout = '0;
  logic rd_en = 0, rd_sel = 0, rd_valid;
  logic [CTRL_W-1:0] rd_data;
  logic wd_kick = 0, trig_crc = 0, trig_ext_err = 0, trig_user = 0, trig_cfg_rst = 0;
  logic app_mode, req_valid;
  logic [4:0] status;
  logic [ADDR_W-1:0] req_addr;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  reconfig_supervisor #(.ADDR_W(ADDR_W), .WD_W(WD_W), .WD_SHIFT(WD_SHIFT)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_app(wr_app), .wr_start(wr_start),
    .wr_wd_en(wr_wd_en), .wr_timeout(wr_timeout), .rd_en(rd_en), .rd_sel(rd_sel),
    .rd_valid(rd_valid), .rd_data(rd_data), .wd_kick(wd_kick), .trig_crc(trig_crc),
    .trig_ext_err(trig_ext_err), .trig_user(trig_user), .trig_cfg_rst(trig_cfg_rst),
    .app_mode(app_mode), .status(status), .req_valid(req_valid), .req_addr(req_addr)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_write(input logic app, input logic [ADDR_W-1:0] a, input logic en, input logic [WD_W-1:0] to);
    wr_app = app; wr_start = a; wr_wd_en = en; wr_timeout = to; wr_en = 1;
    step();
    wr_en = 0;
  endtask

  task automatic do_read(input logic sel, output logic [CTRL_W-1:0] d);
    rd_sel = sel; rd_en = 1;
    step();
    rd_en = 0;
    chk(rd_valid === 1'b1, "R2 rd_valid", rd_valid, 1);
    d = rd_data;
  endtask

  task automatic fire_causes(input logic [4:0] c);
    trig_crc = c[0]; trig_ext_err = c[1]; trig_user = c[2]; trig_cfg_rst = c[3];
    step();
    trig_crc = 0; trig_ext_err = 0; trig_user = 0; trig_cfg_rst = 0;
  endtask

  task automatic to_factory();
    fire_causes(5'b00001);
    step();
  endtask

  task automatic t_reset();
    logic [CTRL_W-1:0] d;
    chk(app_mode === 0, "R1 app_mode", app_mode, 0);
    chk(status === 0, "R1 status", status, 0);
    chk(req_valid === 0, "R1 req_valid", req_valid, 0);
    do_read(0, d);
    chk(d === '0, "R1 control word", d, 0);
  endtask

  task automatic t_write_read();
    logic [CTRL_W-1:0] d;
    do_write(0, 24'hA5C3F1, 1, 12'h9B7);
    do_read(0, d);
    chk(d === {12'h9B7, 1'b1, 24'hA5C3F1, 1'b0}, "R2 factory write readback", d, {12'h9B7, 1'b1, 24'hA5C3F1, 1'b0});
    chk(app_mode === 0, "R2 still factory", app_mode, 0);
  endtask

  task automatic t_app_lock();
    logic [CTRL_W-1:0] d;
    do_write(1, 24'h123456, 0, 12'h005);
    chk(app_mode === 1, "R2 flag set", app_mode, 1);
    do_write(0, 24'hABCDEF, 1, 12'h007);
    chk(app_mode === 1, "R3 flag kept", app_mode, 1);
    do_read(0, d);
    chk(d === {12'h005, 1'b0, 24'h123456, 1'b1}, "R3 write ignored", d, {12'h005, 1'b0, 24'h123456, 1'b1});
  endtask

  task automatic t_user_app();
    fire_causes(5'b00100);
    chk(req_valid === 1, "R10 request pulse", req_valid, 1);
    chk(req_addr === 24'h123456, "R8 user addr app", req_addr, 24'h123456);
    chk(app_mode === 1, "R8 flag kept", app_mode, 1);
    chk(status === 5'b00100, "R9 status user", status, 5'b00100);
    step();
    chk(req_valid === 0, "R10 pulse one cycle", req_valid, 0);
  endtask

  task automatic t_error(input logic [4:0] c, input string tag);
    do_write(1, 24'h0F0F0F, 0, 12'h001);
    fire_causes(c);
    chk(req_valid === 1, tag, req_valid, 1);
    chk(req_addr === 0, tag, req_addr, 0);
    chk(app_mode === 0, tag, app_mode, 0);
    chk(status === c, tag, status, c);
    step();
  endtask

  task automatic t_user_factory();
    fire_causes(5'b00100);
    chk(req_addr === 0, "R8 user addr factory", req_addr, 0);
    chk(app_mode === 0, "R8 factory flag", app_mode, 0);
    step();
  endtask

  task automatic t_multi();
    logic [CTRL_W-1:0] d;
    do_write(1, 24'h777777, 0, 12'h001);
    fire_causes(5'b00101);
    chk(status === 5'b00101, "R9 simultaneous causes", status, 5'b00101);
    chk(req_addr === 0, "R7 error wins addr", req_addr, 0);
    chk(app_mode === 0, "R7 multi fallback", app_mode, 0);
    repeat (3) step();
    do_read(1, d);
    chk(d === 38'b00101, "R9 status held and read", d, 5'b00101);
  endtask

  task automatic t_wd_timeout();
    int hit = 0;
    do_write(1, 24'h222222, 1, 12'h003);
    for (int i = 0; i < 12; i++) begin
      step();
      if (req_valid) hit++;
    end
    chk(hit == 0, "R4 no early fire", hit, 0);
    step();
    chk(req_valid === 1, "R4 fires at terminal", req_valid, 1);
    chk(status === 5'b10000, "R4 watchdog status", status, 5'b10000);
    chk(app_mode === 0, "R7 watchdog fallback", app_mode, 0);
    chk(req_addr === 0, "R7 watchdog addr", req_addr, 0);
    step();
  endtask

  task automatic t_wd_kick();
    int hit = 0;
    do_write(1, 24'h333333, 1, 12'h003);
    repeat (8) step();
    wd_kick = 1;
    step();
    wd_kick = 0;
    for (int i = 0; i < 12; i++) begin
      step();
      if (req_valid) hit++;
    end
    chk(hit == 0, "R5 kick delays expiry", hit, 0);
    step();
    chk(req_valid === 1, "R5 fires after restart", req_valid, 1);
    step();
  endtask

  task automatic t_wd_off();
    int hit = 0;
    do_write(1, 24'h444444, 0, 12'h001);
    for (int i = 0; i < 30; i++) begin
      step();
      if (req_valid) hit++;
    end
    chk(hit == 0, "R6 disabled no fire", hit, 0);
    to_factory();
    do_write(0, 24'h444444, 1, 12'h001);
    hit = 0;
    for (int i = 0; i < 30; i++) begin
      step();
      if (req_valid) hit++;
    end
    chk(hit == 0, "R6 factory no fire", hit, 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    t_reset();
    t_write_read();
    t_app_lock();
    t_user_app();
    to_factory();
    t_user_factory();
    t_error(5'b00001, "R7 crc");
    t_error(5'b00010, "R7 ext err");
    t_error(5'b01000, "R7 cfg reset");
    t_multi();
    t_wd_timeout();
    t_wd_kick();
    t_wd_off();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule